// File: doc/BRIEF.md
# NAND Bus-Cycle Front End

This block is the device-side interface of a byte-wide NAND-style memory. One 8-bit port carries commands, addresses and data, multiplexed in time. Active-low chip enable, write strobe, read strobe and write protect sit beside two active-high latch selects, one for commands and one for addresses. All of these are brought into the system clock domain through a synchroniser. Strobe edges are detected there. Each rising write strobe is classified as a command, address or data cycle by the latch-select levels.

A falling read strobe shifts out one byte of a single-page stand-in buffer and advances a column counter. A fixed-length busy timer stands in for the array during read, program and erase. The ready/busy indication is an open-drain drive-low enable, and the pull-up is external. The port is strobe-driven with no valid/ready handshake. The host paces every transfer, so there is no back-pressure to describe. Control and status pins are plain levels.

Commands recognised: 0x00 then 0x30 (read), 0x80 then 0x10 (program), 0x60 then 0xD0 (erase), 0xFF (reset).

Top module: `nand_bus_frontend`

## Requirements
- R1: Every pin passes through a SYNC_STAGES-deep synchroniser. A strobe edge whose new level is first captured at clock edge k takes effect at edge k+SYNC_STAGES. The level-derived outputs io_oe and standby follow their pins SYNC_STAGES-1 edges after capture.
- R2: A rising write strobe with cle=1, ale=0 and ce_n=0 is a command cycle. Busy starts only for 0x30 after 0x00, 0x10 after 0x80, or 0xD0 after 0x60. Any other command clears the pending setup, so an unmatched confirm is ignored.
- R3: A rising write strobe with ale=1, cle=0 is an address cycle. The first COL_CYCLES bytes set the column counter, least significant byte first. The next ROW_CYCLES bytes set row_addr, least significant byte first. Further bytes are ignored. Every command cycle restarts the byte count.
- R4: A rising write strobe with cle=0, ale=0 is a data cycle. After a program setup (0x80) it writes the byte to the page at the column and increments the column. Otherwise it has no effect.
- R5: A write strobe with cle and ale both high is ignored.
- R6: On a falling read strobe with ce_n=0, io_out takes the page byte at the column and the column increments. The column wraps modulo PAGE_BYTES.
- R7: io_oe is high exactly while the synchronised ce_n and re_n are both low and the block is ready.
- R8: rb_drive_low rises on the edge that accepts a confirm command and stays high for exactly BUSY_CYCLES clock cycles. While it is high, every write and read strobe is ignored.
- R9: When an erase busy period ends, every page byte reads 0xFF.
- R10: The program and erase confirms are ignored unless wp_n is high at the confirm. They are also ignored unless wp_n has stayed high since the setup command; a low pulse in between disarms them.
- R11: standby is high exactly while the synchronised ce_n is high and the block is ready. It stays low through a busy period even when ce_n is high.
- R12: While ce_n is high, write and read strobes are ignored.
- R13: After reset, rb_drive_low=0, io_oe=0, io_out=0x00, standby=1, row_addr=0, the column is 0 and every page byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe, active low (latches on rising edge) |
| re_n | input | 1 | Read strobe, active low (shifts on falling edge) |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Shared command/address/data input byte |
| io_out | output | 8 | Read data byte |
| io_oe | output | 1 | Output enable for the shared port |
| rb_drive_low | output | 1 | Open-drain ready/busy pull-down enable (1 = busy) |
| standby | output | 1 | Low-power standby indication |
| row_addr | output | 8*ROW_CYCLES | Row address collected from the address cycles |

## Verification
A write or read strobe is acted on SYNC_STAGES clock edges after the synchroniser first captures it. io_out, the column, the page and rb_drive_low all change on that edge. rb_drive_low then stays set for BUSY_CYCLES edges. io_oe and standby trail their pins by one edge less.

The bench keeps a history of the pin values it drove and replays them at those offsets in a behavioural model. It compares every output at the falling clock edge, half a period after the register updates. The directed reads sample io_out only after the strobe has been low for four edges, well past the decode edge.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       we_n;
    logic       re_n;
    logic       wp_n;
    logic [7:0] io;
  } pins_t;

  localparam pins_t PINS_IDLE = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0, we_n: 1'b1,
                                 re_n: 1'b1, wp_n: 1'b0, io: 8'h00};

  typedef enum logic [1:0] {SET_NONE, SET_READ, SET_PROG, SET_ERASE} setup_e;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE} op_e;

  localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
  localparam logic [7:0] CMD_READ_GO     = 8'h30;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_RESET       = 8'hFF;

endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
  parameter int              WIDTH   = 8,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/nbf_cycle_decode.sv
module nbf_cycle_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io,
  output logic       cmd_evt,
  output logic       addr_evt,
  output logic       data_evt,
  output logic       rd_evt,
  output logic [7:0] byte_o
);

  logic we_q, re_q;
  logic we_rise, re_fall, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign sel      = !ce_n;
  assign we_rise  = we_n & !we_q;
  assign re_fall  = !re_n & re_q;

  assign cmd_evt  = sel & we_rise &  cle & !ale;
  assign addr_evt = sel & we_rise & !cle &  ale;
  assign data_evt = sel & we_rise & !cle & !ale;
  assign rd_evt   = sel & re_fall;
  assign byte_o   = io;

endmodule

// File: rtl/nbf_page_buf.sv
module nbf_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             fill,
  input  logic [COL_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= 8'hFF;
    end else if (fill) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  assert_fill_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill && wr_en));

endmodule

// File: rtl/nbf_busy_timer.sv
module nbf_busy_timer #(
  parameter int CYCLES = 20,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready,
  output logic done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (ready) begin
      if (start) begin
        ready <= 1'b0;
        cnt   <= CW'(CYCLES - 1);
      end
    end else if (cnt == '0) begin
      ready <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = !ready && (cnt == '0);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (cnt < CW'(CYCLES)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cnt) == '0));

endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend #(
  parameter int PAGE_BYTES  = 16,
  parameter int COL_CYCLES  = 1,
  parameter int ROW_CYCLES  = 2,
  parameter int BUSY_CYCLES = 20,
  parameter int SYNC_STAGES = 2,
  localparam int COL_W       = $clog2(PAGE_BYTES),
  localparam int ROW_W       = 8 * ROW_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             wp_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             rb_drive_low,
  output logic             standby,
  output logic [ROW_W-1:0] row_addr
);
  import nbf_pkg::*;

  localparam int ADDR_CYCLES = COL_CYCLES + ROW_CYCLES;
  localparam int IDX_W       = $clog2(ADDR_CYCLES + 1);
  localparam int PW          = $bits(pins_t);

  pins_t pins_raw, pins_s;
  logic  cmd_evt, addr_evt, data_evt, rd_evt;
  logic [7:0] byte_s, rdata;
  logic  ready, done, start;
  op_e   op_sel, op_q;
  setup_e setup;
  logic  armed;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] col, col_nxt;
  logic [ROW_W-1:0] row_nxt;
  logic  buf_wr, buf_fill;

  assign pins_raw = '{ce_n: ce_n, cle: cle, ale: ale, we_n: we_n,
                      re_n: re_n, wp_n: wp_n, io: io_in};

  nbf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
  );

  nbf_cycle_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .ce_n(pins_s.ce_n), .cle(pins_s.cle), .ale(pins_s.ale),
    .we_n(pins_s.we_n), .re_n(pins_s.re_n), .io(pins_s.io),
    .cmd_evt(cmd_evt), .addr_evt(addr_evt), .data_evt(data_evt),
    .rd_evt(rd_evt), .byte_o(byte_s)
  );

  nbf_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .done(done)
  );

  // confirm decode: only a matching, still-armed setup starts the array
  always_comb begin
    start  = 1'b0;
    op_sel = OP_READ;
    if (cmd_evt && ready) begin
      unique case (byte_s)
        CMD_READ_GO: begin
          start  = (setup == SET_READ);
          op_sel = OP_READ;
        end
        CMD_PROG_GO: begin
          start  = (setup == SET_PROG) && armed && pins_s.wp_n;
          op_sel = OP_PROG;
        end
        CMD_ERASE_GO: begin
          start  = (setup == SET_ERASE) && armed && pins_s.wp_n;
          op_sel = OP_ERASE;
        end
        default: start = 1'b0;
      endcase
    end
  end

  // address byte steering: column bytes first, then row bytes
  always_comb begin
    col_nxt = col;
    row_nxt = row_addr;
    for (int b = 0; b < COL_W; b++)
      if (int'(idx) == b / 8) col_nxt[b] = byte_s[b % 8];
    for (int j = 0; j < ROW_CYCLES; j++)
      if (int'(idx) == COL_CYCLES + j) row_nxt[8*j +: 8] = byte_s;
  end

  assign buf_wr   = data_evt && ready && (setup == SET_PROG);
  assign buf_fill = done && (op_q == OP_ERASE);

  nbf_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_wr), .waddr(col), .wdata(byte_s),
    .fill(buf_fill), .raddr(col), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup    <= SET_NONE;
      armed    <= 1'b0;
      idx      <= '0;
      col      <= '0;
      row_addr <= '0;
      io_out   <= 8'h00;
      op_q     <= OP_READ;
    end else begin
      if (ready) begin
        if (cmd_evt) begin
          idx <= '0;
          unique case (byte_s)
            CMD_READ_SETUP:  setup <= SET_READ;
            CMD_PROG_SETUP: begin
              setup <= SET_PROG;
              armed <= pins_s.wp_n;
            end
            CMD_ERASE_SETUP: begin
              setup <= SET_ERASE;
              armed <= pins_s.wp_n;
            end
            CMD_RESET: begin
              setup <= SET_NONE;
              armed <= 1'b0;
              col   <= '0;
            end
            default: setup <= SET_NONE;
          endcase
        end
        if (addr_evt && (int'(idx) < ADDR_CYCLES)) begin
          idx      <= idx + 1'b1;
          col      <= col_nxt;
          row_addr <= row_nxt;
        end
        if (buf_wr) col <= col + 1'b1;
        if (rd_evt) begin
          io_out <= rdata;
          col    <= col + 1'b1;
        end
      end
      if (start) op_q <= op_sel;
      if (!pins_s.wp_n) armed <= 1'b0;
    end
  end

  assign io_oe        = !pins_s.ce_n && !pins_s.re_n && ready;
  assign standby      =  pins_s.ce_n && ready;
  assign rb_drive_low = !ready;

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cmd_evt));

  assert_read_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && ready) |=> (col == $past(col) + 1'b1));

  assert_col_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(col));

  assert_wp_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_s.wp_n |=> !armed);

endmodule

// File: tb/nand_bus_frontend_test.sv
module nand_bus_frontend_test;

  localparam int S    = 2;
  localparam int BUSY = 20;
  localparam int PG   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb_drive_low, standby;
  logic [15:0] row_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nand_bus_frontend #(.PAGE_BYTES(PG), .COL_CYCLES(1), .ROW_CYCLES(2),
                      .BUSY_CYCLES(BUSY), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rb_drive_low(rb_drive_low), .standby(standby), .row_addr(row_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pin vector bits: 13 ce_n, 12 cle, 11 ale, 10 we_n, 9 re_n, 8 wp_n, 7:0 io
  localparam logic [13:0] IDLE_VEC = 14'b1_0_0_1_1_0_00000000;
  logic [13:0] hist[$];
  bit   m_ready;
  int   m_left;
  int   m_op;      // 0 read, 1 program, 2 erase
  int   m_setup;   // 0 none, 1 read, 2 program, 3 erase
  bit   m_armed;
  int   m_idx;
  int   m_col;
  logic [15:0] m_row;
  logic [7:0]  m_io;
  logic [7:0]  m_page [PG];
  bit   e_oe, e_sb;
  bit   live = 0;

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i <= S; i++) hist.push_back(IDLE_VEC);
    m_ready = 1; m_left = 0; m_op = 0; m_setup = 0; m_armed = 0;
    m_idx = 0; m_col = 0; m_row = '0; m_io = 8'h00;
    for (int i = 0; i < PG; i++) m_page[i] = 8'hFF;
    e_oe = 0; e_sb = 1;
  endtask

  task automatic model_step(input logic [13:0] now);
    logic [13:0] c, p, s;
    bit sel, we_r, re_f;
    logic [7:0] b;
    c = hist[hist.size() - S];
    p = hist[hist.size() - S - 1];
    b = c[7:0];
    sel  = !c[13];
    we_r = sel && c[10] && !p[10];
    re_f = sel && !c[9] && p[9];
    if (!m_ready) begin
      m_left--;
      if (m_left == 0) begin
        m_ready = 1;
        if (m_op == 2) for (int i = 0; i < PG; i++) m_page[i] = 8'hFF;
      end
    end else begin
      if (we_r && c[12] && !c[11]) begin
        m_idx = 0;
        case (b)
          8'h00: m_setup = 1;
          8'h80: begin m_setup = 2; m_armed = c[8]; end
          8'h60: begin m_setup = 3; m_armed = c[8]; end
          8'h30: begin
            if (m_setup == 1) begin m_ready = 0; m_left = BUSY; m_op = 0; end
            m_setup = 0;
          end
          8'h10: begin
            if (m_setup == 2 && m_armed && c[8]) begin m_ready = 0; m_left = BUSY; m_op = 1; end
            m_setup = 0;
          end
          8'hD0: begin
            if (m_setup == 3 && m_armed && c[8]) begin m_ready = 0; m_left = BUSY; m_op = 2; end
            m_setup = 0;
          end
          8'hFF: begin m_setup = 0; m_armed = 0; m_col = 0; end
          default: m_setup = 0;
        endcase
      end
      if (we_r && !c[12] && c[11] && m_idx < 3) begin
        if (m_idx == 0) m_col = b % PG;
        else m_row[8*(m_idx-1) +: 8] = b;
        m_idx++;
      end
      if (we_r && !c[12] && !c[11] && m_setup == 2) begin
        m_page[m_col] = b;
        m_col = (m_col + 1) % PG;
      end
      if (re_f) begin
        m_io = m_page[m_col];
        m_col = (m_col + 1) % PG;
      end
    end
    if (!c[8]) m_armed = 0;
    hist.push_back(now);
    if (hist.size() > 12) void'(hist.pop_front());
    s = hist[hist.size() - S];
    e_oe = !s[13] && !s[9] && m_ready;
    e_sb = s[13] && m_ready;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step({ce_n, cle, ale, we_n, re_n, wp_n, io_in});
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk("R6 io_out", io_out, m_io);
      chk("R7 io_oe", io_oe, e_oe);
      chk("R8 rb_drive_low (strobe timing R1)", rb_drive_low, !m_ready);
      chk("R11 standby", standby, e_sb);
      chk("R3 row_addr", row_addr, m_row);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); wr(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d); wr(1'b0, 1'b0, d); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    re_n = 1'b0;
    repeat (4) @(negedge clk);
    v = io_out;
    re_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (rb_drive_low) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic addr3(input logic [7:0] c0, input logic [7:0] r0, input logic [7:0] r1);
    adr(c0); adr(r0); adr(r1);
  endtask

  task automatic start_read(input logic [7:0] c0);
    cmd(8'h00); addr3(c0, 8'h00, 8'h00); cmd(8'h30); wait_ready();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 rb_drive_low", rb_drive_low, 1'b0);
    chk("R13 io_oe", io_oe, 1'b0);
    chk("R13 io_out", io_out, 8'h00);
    chk("R13 standby", standby, 1'b1);
    live = 1;
    ce_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 standby drops with ce_n low", standby, 1'b0);

    // R2/R3/R13: read of an erased page, row capture
    cmd(8'h00); addr3(8'h03, 8'h12, 8'h34);
    chk("R3 row_addr", row_addr, 16'h3412);
    cmd(8'h30);
    chk("R2 busy after read confirm", rb_drive_low, 1'b1);
    wait_ready();
    rd(v); chk("R13 erased page byte", v, 8'hFF);

    // R4/R6: program three bytes then read back
    cmd(8'h80); addr3(8'h02, 8'h00, 8'h00);
    dat(8'hA5); dat(8'h5A); dat(8'h3C);
    cmd(8'h10);
    chk("R2 busy after program confirm", rb_drive_low, 1'b1);
    wait_ready();
    start_read(8'h02);
    rd(v); chk("R4 byte 0", v, 8'hA5);
    rd(v); chk("R4 byte 1", v, 8'h5A);
    rd(v); chk("R6 byte 2 auto-increment", v, 8'h3C);

    // R6 wrap at the page end
    cmd(8'h80); addr3(8'h0F, 8'h00, 8'h00);
    dat(8'h11); dat(8'h22); cmd(8'h10); wait_ready();
    start_read(8'h0F);
    rd(v); chk("R6 last column", v, 8'h11);
    rd(v); chk("R6 wrap to column 0", v, 8'h22);

    // R4: data cycle without program setup is ignored
    start_read(8'h00);
    dat(8'h77);
    rd(v); chk("R4 stray data ignored", v, 8'h22);

    // R2: confirm with no matching setup is ignored
    cmd(8'h10);
    repeat (2) @(negedge clk);
    chk("R2 unmatched confirm", rb_drive_low, 1'b0);

    // R5: cle and ale both high is ignored
    wr(1'b1, 1'b1, 8'h60);
    cmd(8'hD0);
    repeat (2) @(negedge clk);
    chk("R5 clashing selects ignored", rb_drive_low, 1'b0);

    // R10: write protect low blocks erase
    wp_n = 1'b0;
    cmd(8'h60); cmd(8'hD0);
    repeat (2) @(negedge clk);
    chk("R10 erase blocked by wp_n", rb_drive_low, 1'b0);
    wp_n = 1'b1;
    cmd(8'h60);
    wp_n = 1'b0; repeat (4) @(negedge clk); wp_n = 1'b1; repeat (4) @(negedge clk);
    cmd(8'hD0);
    repeat (2) @(negedge clk);
    chk("R10 wp_n pulse disarms", rb_drive_low, 1'b0);
    start_read(8'h02);
    rd(v); chk("R10 data preserved", v, 8'hA5);

    // R12: strobes ignored with ce_n high
    ce_n = 1'b1;
    cmd(8'h60); cmd(8'hD0);
    chk("R12 command ignored", rb_drive_low, 1'b0);
    rd(v); chk("R12 read ignored", v, 8'hA5);
    ce_n = 1'b0;
    rd(v); chk("R12 column not advanced", v, 8'h5A);

    // R9/R11/R8: erase; ce_n high during busy; strobes ignored while busy
    cmd(8'h60); cmd(8'hD0);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 no standby while busy", standby, 1'b0);
    ce_n = 1'b0;
    cmd(8'hFF);
    wait_ready();
    chk("R11 ready again", rb_drive_low, 1'b0);
    rd(v); chk("R8 strobe during busy ignored, column kept", v, 8'hFF);
    start_read(8'h02);
    rd(v); chk("R9 erased byte", v, 8'hFF);
    start_read(8'h0F);
    rd(v); chk("R9 erased last byte", v, 8'hFF);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule